// File: doc/BRIEF.md
# FSK Transmit Frame Generator

This block turns bytes written by a host over a simple two-wire serial port (a host-driven shift clock plus a data line) into the asynchronous bit stream that keys a 1200 bit/s FSK tone modulator. A line value of 1 asks the modulator for the mark tone and 0 for the space tone. A separate tone-enable output tells the modulator whether to produce any tone at all; with it low, the modulator output rests at its DC bias.

Each loaded byte goes out framed by a start bit and a stop bit, and no host action is needed for them. When send mode is switched on, the block either keys a continuous mark at once or stays silent until the first byte arrives, depending on a control input sampled at that moment. When the host falls behind, mark idle bits fill the gap, and once idling has begun a minimum number of them are sent before the next start bit. A ready output paces the host. A frequency-pair select input is passed to the modulator unchanged.

Top module: `fsk_tx_framer`

## Requirements
- R1: Every bit on the line lasts exactly CLK_HZ/BIT_HZ clock cycles (1200 bit/s at the default values), and all bit boundaries fall on that grid, counted from the cycle tone_en rises.
- R2: A byte goes out as one start bit (tx_bit = 0), then its data bits with bit 0 first, then one stop bit (tx_bit = 1), with tone_en = 1 throughout.
- R3: The host loads a byte by presenting host_data and raising host_clk once per bit, bit 0 first. Both inputs are synchronised into clk over SYNC_STAGES flops. ready drops on the first accepted rising edge and stays low until the completed byte is moved into a frame.
- R4: ready is high only in send mode with no byte buffered and no partial byte. Rising host_clk edges that arrive while a complete byte is buffered are ignored.
- R5: If hold_off is 0 when send_en is first seen high, then from the next cycle tone_en = 1 and tx_bit = 1 (continuous mark) until the first byte's start bit.
- R6: If hold_off is 1 when send_en is first seen high, tone_en stays 0 until a byte is buffered. The first toned bit is then that byte's start bit, beginning at the next bit boundary.
- R7: A byte that is buffered when a stop bit ends has its start bit sent directly after that stop bit, with no idle bit between.
- R8: If no byte is buffered when a stop bit ends, mark idle bits follow. At least MIN_IDLE (default 5) of them are sent before the next start bit, which then begins at the first bit boundary where both conditions hold.
- R9: When send_en goes low, any buffered or partial byte is dropped at once and ready goes low. The bit in progress completes, and then tone_en = 0 and tx_bit = 1.
- R10: pair_sel follows pair_sel_in with no delay (1 selects the 1200/2200 Hz mark/space pair, 0 selects 1300/2100 Hz).
- R11: In reset and after it, with send_en low: tone_en = 0, tx_bit = 1, ready = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| send_en | input | 1 | Send mode enable |
| hold_off | input | 1 | Sampled on send-mode entry: 0 = lead with mark, 1 = stay silent until a byte |
| pair_sel_in | input | 1 | Frequency pair request |
| host_clk | input | 1 | Host serial shift clock (asynchronous) |
| host_data | input | 1 | Host serial data, bit 0 first |
| ready | output | 1 | High when the next byte may be loaded |
| tx_bit | output | 1 | Line bit to the modulator: 1 mark, 0 space |
| tone_en | output | 1 | 1 = modulate tx_bit, 0 = no tone (DC bias) |
| pair_sel | output | 1 | Frequency pair select to the modulator |

## Verification
The bench builds the block with CLK_HZ = 9600 and BIT_HZ = 1200, so each bit lasts eight clocks. It keeps MIN_IDLE at 5 and SYNC_STAGES at 2. The short bit lets a single run cover a lead-in of mark, a frame followed directly by another, an idle gap that has to reach its minimum, bits ignored while the buffer is full, an abort in the middle of a frame, and a silent entry, all against a per-cycle queue-based model. With eight-clock bits, a host byte (about 64 clocks) can arrive either inside a frame or during idle, which exercises both the back-to-back path and the idle path.

// File: rtl/fsk_tx_pkg.sv
// Shared types for the FSK transmit frame generator.
package fsk_tx_pkg;

    // Line state of the framer: what the current bit on the line is.
    typedef enum logic [2:0] {
        S_OFF   = 3'd0,   // send mode off, no tone
        S_LEAD  = 3'd1,   // continuous mark before the first byte
        S_QUIET = 3'd2,   // send mode on, silent until the first byte
        S_START = 3'd3,   // start bit (space)
        S_DATA  = 3'd4,   // data bit from the frame register
        S_STOP  = 3'd5,   // stop bit (mark)
        S_IDLE  = 3'd6    // idle fill (mark) after a frame
    } line_state_t;

endpackage

// File: rtl/fsk_tx_sync.sv
// Brings the host serial clock and data into the clk domain and reports
// each rising edge of the host clock with the data value that goes with it.
// Assumes the host holds data stable around its clock edge for longer than
// STAGES+1 clk cycles.
module fsk_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_clk,
    input  logic host_data,
    output logic clk_rise,
    output logic data_s
);

    logic [STAGES-1:0] ck_q;
    logic [STAGES-1:0] dt_q;
    logic              ck_last;

    // Synchronising flop chains for clock and data, plus an edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q    <= '0;
            dt_q    <= '0;
            ck_last <= 1'b0;
        end else begin
            ck_q    <= {ck_q[STAGES-2:0], host_clk};
            dt_q    <= {dt_q[STAGES-2:0], host_data};
            ck_last <= ck_q[STAGES-1];
        end
    end

    // Rising edge of the synchronised host clock.
    always_comb begin
        clk_rise = ck_q[STAGES-1] & ~ck_last;
        data_s   = dt_q[STAGES-1];
    end

    // One edge is reported as one pulse, never two in a row.
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rise |=> !clk_rise);

endmodule

// File: rtl/fsk_tx_shift_in.sv
// Assembles serially received bits (bit 0 first) into a byte and holds it
// until the framer takes it. Bits arriving while a byte is held are dropped.
// Leaving send mode clears both the partial and the held byte.
module fsk_tx_shift_in #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 send_en,
    input  logic                 bit_rise,
    input  logic                 bit_val,
    input  logic                 take,
    output logic                 full,
    output logic                 loading,
    output logic [DATA_BITS-1:0] byte_out
);

    localparam int CW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] LAST_BIT = CW'(DATA_BITS - 1);

    logic [CW-1:0]        cnt;
    logic [DATA_BITS-1:0] shreg;
    logic [DATA_BITS-1:0] next_shreg;

    // New shift value: the incoming bit enters at the top, earlier bits move down.
    always_comb begin
        next_shreg = {bit_val, shreg[DATA_BITS-1:1]};
    end

    // Bit counter, shift register and holding buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            full     <= 1'b0;
            byte_out <= '0;
        end else if (!send_en) begin
            cnt  <= '0;
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (bit_rise && !full) begin
            shreg <= next_shreg;
            if (cnt == LAST_BIT) begin
                cnt      <= '0;
                full     <= 1'b1;
                byte_out <= next_shreg;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // A partial byte is in progress.
    always_comb begin
        loading = (cnt != '0);
    end

    // A held byte survives until it is taken or send mode ends.
    p_hold_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take && send_en) |=> full);

    // Leaving send mode empties the buffer on the next cycle.
    p_clear_on_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !send_en |=> (!full && !loading));

endmodule

// File: rtl/fsk_tx_baud.sv
// Bit-period timer. It counts clk cycles while the line is active and pulses
// tick in the last cycle of each bit. It restarts from zero whenever the line
// is off.
module fsk_tx_baud #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    // Cycle counter within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // End-of-bit strobe.
    always_comb begin
        tick = run && (cnt == LAST);
    end

    // Bit periods longer than one cycle never produce adjacent ticks.
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (CLKS_PER_BIT > 1)) |=> !tick);

endmodule

// File: rtl/fsk_tx_line.sv
// Line sequencer: decides on every bit boundary what the next line bit is.
// It handles lead-in mark or silence, start/data/stop framing, idle fill with
// a minimum idle run, and abort at the end of the bit in progress.
// Assumes tick marks the last cycle of a bit and full/byte_in come from the
// serial buffer.
module fsk_tx_line
    import fsk_tx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int MIN_IDLE  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 send_en,
    input  logic                 hold_off,
    input  logic                 tick,
    input  logic                 full,
    input  logic [DATA_BITS-1:0] byte_in,
    output logic                 take,
    output logic                 running,
    output logic                 tx_bit,
    output logic                 tone_en
);

    localparam int IW = $clog2(MIN_IDLE + 1);
    localparam int BW = $clog2(DATA_BITS);
    localparam logic [IW-1:0] IDLE_ENOUGH = IW'(MIN_IDLE);
    localparam logic [BW-1:0] LAST_DATA   = BW'(DATA_BITS - 1);

    line_state_t          state;
    logic [IW-1:0]        idle_cnt;
    logic [BW-1:0]        bit_idx;
    logic [DATA_BITS-1:0] frame_q;
    logic                 may_start;

    // Whether the current state lets a buffered byte begin at this boundary.
    always_comb begin
        case (state)
            S_LEAD, S_QUIET, S_STOP: may_start = 1'b1;
            S_IDLE:                  may_start = (idle_cnt >= IDLE_ENOUGH);
            default:                 may_start = 1'b0;
        endcase
        take = tick && send_en && full && may_start;
    end

    // Line state, data index, idle counter and frame register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_OFF;
            idle_cnt <= '0;
            bit_idx  <= '0;
            frame_q  <= '0;
        end else if (state == S_OFF) begin
            if (send_en) begin
                state <= hold_off ? S_QUIET : S_LEAD;
            end
        end else if (tick) begin
            if (!send_en) begin
                state <= S_OFF;
            end else if (take) begin
                state   <= S_START;
                frame_q <= byte_in;
            end else begin
                case (state)
                    S_START: begin
                        state   <= S_DATA;
                        bit_idx <= '0;
                    end
                    S_DATA: begin
                        if (bit_idx == LAST_DATA) begin
                            state <= S_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            frame_q <= frame_q >> 1;
                        end
                    end
                    S_STOP: begin
                        state    <= S_IDLE;
                        idle_cnt <= IW'(1);
                    end
                    S_IDLE: begin
                        if (idle_cnt < IDLE_ENOUGH) begin
                            idle_cnt <= idle_cnt + 1'b1;
                        end
                    end
                    default: state <= state;
                endcase
            end
        end
    end

    // Line outputs from the current state.
    always_comb begin
        running = (state != S_OFF);
        tone_en = (state != S_OFF) && (state != S_QUIET);
        case (state)
            S_START: tx_bit = 1'b0;
            S_DATA:  tx_bit = frame_q[0];
            default: tx_bit = 1'b1;
        endcase
    end

    // Idle fill ends only after the minimum run.
    p_idle_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && $past(state) == S_IDLE) |-> ($past(idle_cnt) >= IDLE_ENOUGH));

    // A stop bit is followed by a start bit, idle fill, or the off state.
    p_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_STOP && state != S_STOP) |-> (state inside {S_START, S_IDLE, S_OFF}));

    // Send mode dropped at a bit boundary turns the line off.
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !send_en) |=> (state == S_OFF));

    // Silent entry stays silent until a byte is framed.
    p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_QUIET && !full) |=> (state inside {S_QUIET, S_OFF}));

endmodule

// File: rtl/fsk_tx_framer.sv
// FSK transmit frame generator top. It joins the host serial synchroniser,
// the byte buffer, the bit timer and the line sequencer, and produces the
// host ready flag. Assumes host_clk is much slower than clk.
module fsk_tx_framer #(
    parameter int CLK_HZ      = 3_686_400,
    parameter int BIT_HZ      = 1200,
    parameter int DATA_BITS   = 8,
    parameter int MIN_IDLE    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic send_en,
    input  logic hold_off,
    input  logic pair_sel_in,
    input  logic host_clk,
    input  logic host_data,
    output logic ready,
    output logic tx_bit,
    output logic tone_en,
    output logic pair_sel
);

    localparam int CLKS_PER_BIT = CLK_HZ / BIT_HZ;

    logic                 clk_rise;
    logic                 data_s;
    logic                 take;
    logic                 full;
    logic                 loading;
    logic                 running;
    logic                 tick;
    logic [DATA_BITS-1:0] byte_q;

    fsk_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_clk  (host_clk),
        .host_data (host_data),
        .clk_rise  (clk_rise),
        .data_s    (data_s)
    );

    fsk_tx_shift_in #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .send_en  (send_en),
        .bit_rise (clk_rise),
        .bit_val  (data_s),
        .take     (take),
        .full     (full),
        .loading  (loading),
        .byte_out (byte_q)
    );

    fsk_tx_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .tick  (tick)
    );

    fsk_tx_line #(.DATA_BITS(DATA_BITS), .MIN_IDLE(MIN_IDLE)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .send_en  (send_en),
        .hold_off (hold_off),
        .tick     (tick),
        .full     (full),
        .byte_in  (byte_q),
        .take     (take),
        .running  (running),
        .tx_bit   (tx_bit),
        .tone_en  (tone_en)
    );

    // Host pacing flag and frequency-pair pass-through.
    always_comb begin
        ready    = send_en && !full && !loading;
        pair_sel = pair_sel_in;
    end

    // A freshly completed byte holds the host off.
    p_ready_on_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> !ready);

    // No tone outside send mode once the bit in progress has finished.
    p_off_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!send_en && !running) |-> (!tone_en && tx_bit));

endmodule

// File: tb/fsk_tx_framer_tb.sv
// Bench: a queue-based per-cycle line model compared on every clock,
// plus targeted checks of framing, bit length and mode entry.
module fsk_tx_framer_tb;

    localparam int CLK_HZ = 9600;
    localparam int BIT_HZ = 1200;
    localparam int CPB    = CLK_HZ / BIT_HZ;
    localparam int MINI   = 5;
    localparam int SYNC   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send_en = 1'b0;
    logic hold_off = 1'b0;
    logic pair_sel_in = 1'b0;
    logic host_clk = 1'b0;
    logic host_data = 1'b0;
    logic ready, tx_bit, tone_en, pair_sel;

    int errors = 0;
    int checks = 0;
    string tag = "R11";

    always #2.5 clk = ~clk;

    fsk_tx_framer #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ), .DATA_BITS(8),
                    .MIN_IDLE(MINI), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .send_en(send_en), .hold_off(hold_off),
        .pair_sel_in(pair_sel_in), .host_clk(host_clk), .host_data(host_data),
        .ready(ready), .tx_bit(tx_bit), .tone_en(tone_en), .pair_sel(pair_sel)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int  ck_hist[$];
    int  dt_hist[$];
    bit  m_on, m_tone, m_bit, m_idle, m_framed, m_have;
    int  m_phase, m_gap, m_nb;
    bit  m_bits[$];
    logic [7:0] m_acc, m_pend;

    always @(posedge clk) begin
        bit rise, dval, took;
        if (!rst_n) begin
            ck_hist = {}; dt_hist = {};
            for (int i = 0; i <= SYNC; i++) begin ck_hist.push_back(0); dt_hist.push_back(0); end
            m_on = 0; m_tone = 0; m_bit = 1; m_idle = 0; m_framed = 0; m_have = 0;
            m_phase = 0; m_gap = 0; m_nb = 0; m_bits = {}; m_acc = 0; m_pend = 0;
        end else begin
            rise = (ck_hist[SYNC-1] == 1) && (ck_hist[SYNC] == 0);
            dval = dt_hist[SYNC-1][0];
            took = 0;
            if (!m_on) begin
                if (send_en) begin
                    m_on = 1; m_phase = 0; m_tone = !hold_off; m_bit = 1;
                    m_idle = 0; m_framed = 0; m_bits = {};
                end
            end else if (m_phase == CPB - 1) begin
                m_phase = 0;
                if (!send_en) begin
                    m_on = 0; m_tone = 0; m_bit = 1; m_bits = {}; m_idle = 0;
                end else begin
                    if (m_idle) m_gap++;
                    if (m_bits.size() > 0) begin
                        m_bit = m_bits.pop_front(); m_idle = 0;
                    end else if (m_have && (!m_idle || m_gap >= MINI)) begin
                        took = 1;
                        m_bits.push_back(0);
                        for (int i = 0; i < 8; i++) m_bits.push_back(m_pend[i]);
                        m_bits.push_back(1);
                        m_bit = m_bits.pop_front();
                        m_tone = 1; m_idle = 0; m_gap = 0; m_framed = 1;
                    end else if (m_framed) begin
                        m_bit = 1; m_idle = 1;
                    end
                end
            end else begin
                m_phase++;
            end
            if (!send_en) begin
                m_nb = 0; m_have = 0;
            end else if (took) begin
                m_have = 0;
            end else if (rise && !m_have) begin
                m_acc[m_nb] = dval; m_nb++;
                if (m_nb == 8) begin m_pend = m_acc; m_have = 1; m_nb = 0; end
            end
            void'(ck_hist.pop_back()); ck_hist.push_front(int'(host_clk));
            void'(dt_hist.pop_back()); dt_hist.push_front(int'(host_data));
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(tag, tone_en, m_tone, "tone_en vs model");
            check(tag, tx_bit, m_bit, "tx_bit vs model");
            check(tag, ready, send_en && !m_have && (m_nb == 0), "ready vs model");
        end
    end

    // R1: toned runs of equal bits are whole numbers of bit periods.
    int  run_len = 0;
    logic prev_bit = 1'b1, prev_tone = 1'b0;
    always @(negedge clk) begin
        if (tone_en && prev_tone && tx_bit != prev_bit) begin
            checks++;
            if (run_len % CPB != 0) begin
                errors++;
                $display("FAIL R1 run length: actual=%0d expected multiple of %0d", run_len, CPB);
            end
            run_len = 1;
        end else if (tone_en != prev_tone) begin
            run_len = 1;
        end else begin
            run_len++;
        end
        prev_bit = tx_bit; prev_tone = tone_en;
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            host_data = b[i];
            cyc(3); host_clk = 1'b1;
            cyc(3); host_clk = 1'b0;
            cyc(2);
        end
    endtask

    task automatic wait_ready();
        int guard = 0;
        while (!ready && guard < 5000) begin cyc(1); guard++; end
    endtask

    // R2: capture one frame after a mark-to-space fall and compare bit by bit.
    task automatic capture_frame(input logic [7:0] b);
        logic [9:0] exp;
        int guard = 0;
        exp = {1'b1, b, 1'b0};
        @(negedge clk);
        while (!(tone_en && prev_bit == 1'b1 && tx_bit == 1'b0) && guard < 5000) begin
            @(negedge clk); guard++;
        end
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            check("R2", tx_bit, exp[i], $sformatf("frame bit %0d", i));
            repeat (CPB) @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(4);
        @(negedge clk);
        check("R11", tone_en, 1'b0, "tone_en in reset");
        check("R11", tx_bit, 1'b1, "tx_bit in reset");
        check("R11", ready, 1'b0, "ready in reset");
        @(posedge clk); #1; rst_n = 1'b1;
        cyc(3);
        @(negedge clk);
        check("R11", tone_en, 1'b0, "tone_en after reset");
        check("R11", ready, 1'b0, "ready after reset");

        // R10: pass-through both ways.
        pair_sel_in = 1'b1; #1;
        check("R10", pair_sel, 1'b1, "pair_sel high");
        pair_sel_in = 1'b0; #1;
        check("R10", pair_sel, 1'b0, "pair_sel low");

        // R5: lead-in mark.
        tag = "R5";
        @(posedge clk); #1; hold_off = 1'b0; send_en = 1'b1;
        cyc(2);
        @(negedge clk);
        check("R5", tone_en, 1'b1, "lead tone on");
        check("R5", tx_bit, 1'b1, "lead mark");
        check("R4", ready, 1'b1, "ready in empty send mode");
        cyc(3 * CPB + 3);

        // R3/R2: first byte, framed and checked.
        tag = "R3 R2";
        fork
            send_byte(8'hA5);
            capture_frame(8'hA5);
        join_any
        // R7: next byte while the first frame is on the line.
        tag = "R7";
        wait_ready();
        send_byte(8'h3C);
        wait fork;
        wait_ready();
        cyc(25 * CPB);

        // R8: bytes landing at several points of the idle run.
        tag = "R8";
        for (int k = 0; k < 4; k++) begin
            wait_ready();
            send_byte(8'h81 ^ 8'(k * 37));
            cyc(k * 5 + 11 * CPB);
        end
        wait_ready();
        cyc(2 * CPB + 3);

        // R4: byte held while a frame runs; extra bits must be ignored.
        tag = "R4";
        send_byte(8'h0F);
        wait_ready();
        send_byte(8'hF0);
        send_byte(8'hFF);
        cyc(4 * CPB);

        // R9: abort mid-frame.
        tag = "R9";
        @(posedge clk); #1; send_en = 1'b0;
        @(negedge clk);
        check("R9", ready, 1'b0, "ready low on exit");
        cyc(CPB + 2);
        @(negedge clk);
        check("R9", tone_en, 1'b0, "tone off after abort");
        check("R9", tx_bit, 1'b1, "line rests after abort");
        cyc(3 * CPB);

        // R6: silent entry.
        tag = "R6";
        @(posedge clk); #1; hold_off = 1'b1; send_en = 1'b1;
        cyc(3 * CPB + 5);
        @(negedge clk);
        check("R6", tone_en, 1'b0, "silent before byte");
        fork
            send_byte(8'h55);
            capture_frame(8'h55);
        join
        check("R6", tone_en, 1'b1, "tone after silent start");
        cyc(8 * CPB);

        // R1: leave and finish.
        tag = "R1 R9";
        @(posedge clk); #1; send_en = 1'b0;
        cyc(2 * CPB);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule